// File: doc/BRIEF.md
# All-One-Polynomial Field Multiplier (redundant basis)

This block multiplies two elements of the binary field GF(2^M). The field comes from the irreducible polynomial whose M+1 coefficients are all one. Every element is carried as M+1 coefficients instead of M. In that form multiplication becomes a cyclic convolution modulo x^(M+1)+1, because x^(M+1) equals 1 in this ring. The wrap-around therefore replaces any separate reduction network.

Each output coefficient is the XOR of M+1 two-input AND terms, summed through a balanced XOR tree. The whole product is formed in one combinational pass. An optional output register can be enabled by a parameter. The redundant product is also converted back to the ordinary M-bit polynomial basis on a second output.

A caller who holds standard M-bit operands enters them in redundant form by putting a zero in the top coefficient. Both redundant encodings of any element then convert back to the same M-bit value.

Top module: `aop_mul_top`

## Requirements
- R1: The width parameter M is legal only when M+1 is prime and 2 has multiplicative order M modulo M+1. Within 2..20 the legal values are exactly 2, 4, 10, 12 and 18. The default is 4.
- R2: Bit k of `prod` equals the XOR, over all i from 0 to M, of `op_a[i] & op_b[(k-i) mod (M+1)]`.
- R3: The operands are standard M-bit values x and y, each given with bit M at zero. Then `prod_std` equals x times y computed as a polynomial product reduced by 1+x+...+x^M.
- R4: `prod_std` is `prod[M-1:0]` when `prod[M]` is 0. When `prod[M]` is 1, it is the bitwise inverse of `prod[M-1:0]`.
- R5: If `op_a` has only bit j set, `prod` is `op_b` rotated toward higher indices by j places, so bit k moves to (k+j) mod (M+1). With j = 0 this gives back `op_b` unchanged.
- R6: A zero operand gives a zero `prod`. An all-ones `op_a` gives an all-zero `prod` when `op_b` has even parity and an all-ones `prod` otherwise. In both cases `prod_std` is zero.
- R7: With REG_OUT=1, `prod` and `prod_std` take the product of the operands present before a rising clock edge at that edge, and hold it until the next edge. With REG_OUT=0 they follow the operands in the same cycle.
- R8: With REG_OUT=1, `prod` is zero while `rst_n` is low. After `rst_n` rises, the output register stays in reset through two more rising edges and first captures a product on the third.
- R9: Swapping `op_a` and `op_b` leaves `prod` and `prod_std` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register and the reset synchronizer |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_a | input | M+1 | First operand, redundant coefficients, bit i weights x^i |
| op_b | input | M+1 | Second operand, same encoding |
| prod | output | M+1 | Product in redundant form |
| prod_std | output | M | Product converted to the M-bit polynomial basis |

## Verification
On every cycle the assertions check several algebraic identities of the multiplier. Multiplying by a single power of x must rotate the other operand. A zero operand must annihilate the product. An all-ones operand must collapse the product to a parity-driven constant. Both zero encodings must map to a zero standard result. Full correctness of the convolution, agreement with a shift-and-reduce field multiply, commutativity, the reset release timing and the one-cycle latency need the bench. It sweeps every redundant operand pair and every standard operand pair at the default width, and it checks the parameter legality rule over a range of widths.

// File: rtl/aop_pkg.sv
package aop_pkg;

  // Legal field width: M+1 prime and 2 of order M modulo M+1, so that
  // 1 + x + ... + x^M is irreducible over GF(2).
  function automatic bit aop_width_legal(input int m);
    int  p;
    int  t;
    bit  ok;
    p  = m + 1;
    ok = (m >= 2);
    for (int d = 2; d < p; d++) begin
      if ((p % d) == 0) ok = 1'b0;
    end
    t = 1;
    for (int k = 1; k < p - 1; k++) begin
      t = (t * 2) % p;
      if (t == 1) ok = 1'b0;
    end
    return ok;
  endfunction

endpackage

// File: rtl/aop_pp_array.sv
// Partial-product plane: one 2-input AND per operand coefficient pair,
// already arranged by output coefficient so that row k holds the terms
// a_i & b_((k-i) mod N) for i = 0..N-1.
module aop_pp_array #(
  parameter int N = 5
) (
  input  logic [N-1:0]   a,
  input  logic [N-1:0]   b,
  output logic [N*N-1:0] pp
);

  for (genvar k = 0; k < N; k++) begin : g_row
    for (genvar i = 0; i < N; i++) begin : g_col
      localparam int BIDX = (k - i + N) % N;
      assign pp[k*N + i] = a[i] & b[BIDX];
    end
  end

endmodule

// File: rtl/aop_xor_tree.sv
// Balanced binary XOR reduction, depth ceil(log2(N)). Unused leaves of the
// padded power-of-two tree are tied low and fold away in synthesis.
module aop_xor_tree #(
  parameter int N = 5
) (
  input  logic [N-1:0] leaves,
  output logic         y
);

  localparam int LVL = (N > 1) ? $clog2(N) : 0;
  localparam int P   = 1 << LVL;

  logic [2*P-1:1] node;

  for (genvar i = 0; i < P; i++) begin : g_leaf
    if (i < N) begin : g_used
      assign node[P + i] = leaves[i];
    end else begin : g_pad
      assign node[P + i] = 1'b0;
    end
  end

  for (genvar j = 1; j < P; j++) begin : g_inner
    assign node[j] = node[2*j] ^ node[2*j + 1];
  end

  assign y = node[1];

endmodule

// File: rtl/aop_to_std.sv
// Redundant -> standard basis: x^M equals the sum of all lower powers, so a
// set top coefficient complements the remaining M coefficients.
module aop_to_std #(
  parameter int M = 4
) (
  input  logic [M:0]   red,
  output logic [M-1:0] std_o
);

  assign std_o = red[M-1:0] ^ {M{red[M]}};

endmodule

// File: rtl/aop_rst_sync.sv
// Two-stage reset synchronizer: asynchronous assertion, synchronous release.
module aop_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic stg1_q;
  logic stg2_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stg1_q <= 1'b0;
      stg2_q <= 1'b0;
    end else begin
      stg1_q <= 1'b1;
      stg2_q <= stg1_q;
    end
  end

  assign srst_n = stg2_q;

endmodule

// File: rtl/aop_mul_top.sv
module aop_mul_top #(
  parameter int M       = 4,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [M:0]   op_a,
  input  logic [M:0]   op_b,
  output logic [M:0]   prod,
  output logic [M-1:0] prod_std
);

  localparam int N = M + 1;

  // R1: width legality, checked once at start of simulation
  initial begin
    p_width_legal_r1: assert (aop_pkg::aop_width_legal(M))
      else $error("field width M=%0d is not an all-one-polynomial field", M);
  end

  logic [N*N-1:0] pp;
  logic [M:0]     prod_d;
  logic           rst_sync_n;

  aop_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  aop_pp_array #(.N(N)) u_pp (
    .a  (op_a),
    .b  (op_b),
    .pp (pp)
  );

  // R2: one balanced tree per output coefficient (cyclic convolution)
  for (genvar k = 0; k < N; k++) begin : g_acc
    aop_xor_tree #(.N(N)) u_tree (
      .leaves (pp[k*N +: N]),
      .y      (prod_d[k])
    );
  end

  // Rotation of v toward higher indices by the position of the set bit of oh.
  function automatic logic [M:0] rot_by_onehot(input logic [M:0] v,
                                               input logic [M:0] oh);
    logic [M:0] r;
    r = '0;
    for (int j = 0; j < N; j++) begin
      if (oh[j]) r = (v << j) | (v >> (N - j));
    end
    return r;
  endfunction

  if (REG_OUT) begin : g_reg
    logic       cap_en;
    logic [M:0] prod_q;

    assign cap_en = 1'b1;

    always_ff @(posedge clk or negedge rst_sync_n) begin
      if (!rst_sync_n) begin
        prod_q <= '0;
      end else if (cap_en) begin
        prod_q <= prod_d;
      end
    end

    assign prod = prod_q;

    // R8: output held at zero while the synchronized reset is active
    p_reset_zero_r8: assert property (@(posedge clk)
      !rst_sync_n |-> (prod == '0));

    // R5, R7: power-of-x operand rotates the other, one edge later
    p_rotate_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
      $onehot(op_a) |=> (prod == rot_by_onehot($past(op_b), $past(op_a))));

    // R6: zero operand annihilates
    p_zero_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
      ((op_a == '0) || (op_b == '0)) |=> (prod == '0));

    // R6: all-ones operand collapses to a parity constant
    p_allones_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (&op_a) |=> (prod == {N{^$past(op_b)}}));
  end else begin : g_comb
    assign prod = prod_d;

    p_rotate_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
      $onehot(op_a) |-> (prod == rot_by_onehot(op_b, op_a)));

    p_zero_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
      ((op_a == '0) || (op_b == '0)) |-> (prod == '0));

    p_allones_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (&op_a) |-> (prod == {N{^op_b}}));
  end

  aop_to_std #(.M(M)) u_conv (
    .red   (prod),
    .std_o (prod_std)
  );

  // R4, R6: both encodings of zero leave the converter as zero
  p_zero_forms_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((prod == '0) || (&prod)) |-> (prod_std == '0));

endmodule

// File: tb/aop_mul_top_tb.sv
module aop_mul_top_tb;

  localparam int  M        = 4;
  localparam int  N        = M + 1;
  localparam time CLK_PER  = 10ns;
  localparam int  WD_LIMIT = 200000;

  logic         clk;
  logic         rst_n;
  logic [M:0]   op_a;
  logic [M:0]   op_b;
  logic [M:0]   prod;
  logic [M-1:0] prod_std;

  int  checks;
  int  errors;
  bit  done;

  aop_mul_top #(.M(M), .REG_OUT(1'b1)) u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_a     (op_a),
    .op_b     (op_b),
    .prod     (prod),
    .prod_std (prod_std)
  );

  initial clk = 1'b0;
  always #(CLK_PER/2) clk = ~clk;

  // Ring product modulo x^N + 1 via full polynomial product and fold.
  function automatic logic [M:0] ring_mul(input logic [M:0] a, input logic [M:0] b);
    logic [2*M:0] c;
    logic [M:0]   r;
    c = '0;
    for (int i = 0; i <= M; i++) begin
      if (a[i]) c = c ^ ({{M{1'b0}}, b} << i);
    end
    r = c[M:0];
    for (int k = N; k <= 2*M; k++) r[k-N] = r[k-N] ^ c[k];
    return r;
  endfunction

  // Shift-and-XOR field multiply reduced by the all-one polynomial.
  function automatic logic [M-1:0] field_mul(input logic [M-1:0] x, input logic [M-1:0] y);
    logic [M:0] r;
    r = '0;
    for (int i = M-1; i >= 0; i--) begin
      r = r << 1;
      if (r[M]) r = r ^ {N{1'b1}};
      if (y[i]) r = r ^ {1'b0, x};
    end
    return r[M-1:0];
  endfunction

  // Reduce a degree-M polynomial by adding the all-one polynomial if needed.
  function automatic logic [M-1:0] reduce_poly(input logic [M:0] r);
    logic [M:0] t;
    t = r[M] ? (r ^ {N{1'b1}}) : r;
    return t[M-1:0];
  endfunction

  task automatic chk(input logic [M:0] act, input logic [M:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s a=%b b=%b actual=%b expected=%b", req, op_a, op_b, act, exp);
    end
  endtask

  // Called at a falling edge: drive operands, wait one full cycle.
  task automatic apply(input logic [M:0] a, input logic [M:0] b);
    op_a = a;
    op_b = b;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (WD_LIMIT) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R7 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [M:0] prev;
    checks = 0;
    errors = 0;
    done   = 1'b0;
    rst_n  = 1'b0;
    op_a   = 5'b01101;
    op_b   = 5'b10110;

    // R1: legality rule over a range of widths
    for (int m = 2; m <= 20; m++) begin
      bit exp_ok;
      exp_ok = (m == 2) || (m == 4) || (m == 10) || (m == 12) || (m == 18);
      chk({4'b0, aop_pkg::aop_width_legal(m)}, {4'b0, exp_ok}, "R1");
    end

    // R8: reset state
    repeat (3) @(negedge clk);
    chk(prod, '0, "R8 in reset");
    chk({1'b0, prod_std}, '0, "R8 in reset std");

    // R8: release, two edges still in reset, third captures
    op_a  = 5'b00011;
    op_b  = 5'b00101;
    rst_n = 1'b1;
    @(negedge clk);
    chk(prod, '0, "R8 first edge after release");
    @(negedge clk);
    chk(prod, '0, "R8 second edge after release");
    @(negedge clk);
    chk(prod, ring_mul(5'b00011, 5'b00101), "R8 third edge captures");

    // R7: value held before the edge, new value after
    prev = prod;
    op_a = 5'b01000;
    op_b = 5'b00111;
    #(CLK_PER/4);
    chk(prod, prev, "R7 holds before edge");
    @(negedge clk);
    chk(prod, ring_mul(5'b01000, 5'b00111), "R7 updates after edge");

    // R2, R4: every redundant operand pair
    for (int a = 0; a < (1 << N); a++) begin
      for (int b = 0; b < (1 << N); b++) begin
        apply(N'(a), N'(b));
        chk(prod, ring_mul(N'(a), N'(b)), "R2");
        chk({1'b0, prod_std}, {1'b0, reduce_poly(prod)}, "R4");
      end
    end

    // R3, R9: every standard operand pair, both orders
    for (int x = 0; x < (1 << M); x++) begin
      for (int y = 0; y < (1 << M); y++) begin
        apply({1'b0, M'(x)}, {1'b0, M'(y)});
        chk({1'b0, prod_std}, {1'b0, field_mul(M'(x), M'(y))}, "R3");
        prev = prod;
        apply({1'b0, M'(y)}, {1'b0, M'(x)});
        chk(prod, prev, "R9 swapped redundant");
        chk({1'b0, prod_std}, {1'b0, field_mul(M'(x), M'(y))}, "R9 swapped std");
      end
    end

    // R5: single power of x rotates the other operand
    for (int j = 0; j < N; j++) begin
      logic [M:0] b;
      logic [M:0] e;
      b = 5'b10011;
      e = '0;
      for (int k = 0; k < N; k++) e[(k + j) % N] = b[k];
      apply(N'(1) << j, b);
      chk(prod, e, "R5 rotate");
    end

    // R6: zero and all-ones operands
    apply('0, 5'b11011);
    chk(prod, '0, "R6 zero operand");
    apply({N{1'b1}}, 5'b00011);
    chk(prod, '0, "R6 all-ones even parity");
    chk({1'b0, prod_std}, '0, "R6 all-ones even std");
    apply({N{1'b1}}, 5'b00111);
    chk(prod, {N{1'b1}}, "R6 all-ones odd parity");
    chk({1'b0, prod_std}, '0, "R6 all-ones odd std");

    done = 1'b1;
    summary();
    $finish;
  end

endmodule